// File: doc/BRIEF.md
# Soft Interrupt Priority Filter

The filter holds a 17-bit pending soft-interrupt register and a 4-bit interrupt level register. It drives a 17-bit vector of level-sensitive request lines toward the core. Each request line shows whether its pending bit is set and whether the current interrupt level lets that bit through.

Software changes the pending register in three ways. A direct write replaces the whole register. A set write ORs bits in. A clear write removes the selected bits. A timer match pulse from outside sets bit 16, the timer bit. Bit 0 and bit 16 are passed only while the level is below a fixed lock level of 14. Each of bits 1 to 15 is passed only when its bit number is strictly greater than the level.

Both registers can be read back at any time. The request vector is decoded combinationally from the registers, so it follows every register update in the same cycle that the update becomes visible.

Top module: `sip_filter`

## Requirements
- R1: After reset the pending register, the level register and every request line are zero.
- R2: A direct write (`wr_en`) replaces the pending register with `wr_data`. The new value is readable on `rd_pend` one clock edge later.
- R3: A set write (`set_en`) ORs `set_data` into the pending register.
- R4: A clear write (`clr_en`) ANDs the pending register with the complement of `clr_data`.
- R5: A `tmr_match` pulse sets bit 16 of the pending register and leaves the other bits unchanged.
- R6: When several updates arrive in the same cycle, they apply in this order: the direct write first, then the set, then the clear, then the timer bit. As a result, a timer pulse wins over a clear of bit 16.
- R7: `irq_req[0]` and `irq_req[16]` are high exactly when the matching pending bit is set and the level is less than 14.
- R8: For each bit k from 1 to 15, `irq_req[k]` is high exactly when pending bit k is set and k is strictly greater than the level.
- R9: A level write (`lvl_wr_en`) loads `lvl_wr_data`, which is readable on `rd_lvl`. All request lines are re-evaluated against the unchanged pending register in the same cycle the new level appears.
- R10: Request lines are levels. A line stays high for as long as its condition holds, and it drops in the cycle its condition stops holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Direct write strobe for the pending register |
| wr_data | input | 17 | Direct write value |
| set_en | input | 1 | Set write strobe |
| set_data | input | 17 | Bits to set |
| clr_en | input | 1 | Clear write strobe |
| clr_data | input | 17 | Bits to clear |
| tmr_match | input | 1 | Timer match pulse, sets bit 16 |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_data | input | 4 | New interrupt level |
| rd_pend | output | 17 | Pending register readback |
| rd_lvl | output | 4 | Level register readback |
| irq_req | output | 17 | Pending request lines to the core |

## Verification
The bench sweeps the level through all 16 values with every pending bit set. This exposes a design that uses greater-or-equal instead of strictly-greater, or that applies the per-bit rule to bits 0 and 16 instead of the fixed lock of 14; either mistake shows up as a wrong line at the boundary levels 13, 14 and 15. It also drives a timer pulse together with a clear of all bits, and a direct write together with a set and a clear. A design with the wrong update order would lose the timer bit or keep cleared bits. A level write with no other traffic confirms that the pending register is left untouched while the lines change, and held cycles confirm that the lines do not act as one-cycle pulses.

// File: rtl/sip_pkg.sv
package sip_pkg;

    localparam int unsigned SIP_VEC_W   = 17;
    localparam int unsigned SIP_LVL_W   = 4;
    localparam int unsigned SIP_TMR_BIT = 16;
    localparam int unsigned SIP_LOCK    = 14;

    // Update strobes presented to the pending register in one cycle
    typedef struct packed {
        logic wr;
        logic set;
        logic clr;
        logic tmr;
    } sip_ops_t;

endpackage

// File: rtl/sip_pend_reg.sv
module sip_pend_reg
    import sip_pkg::*;
#(
    parameter int unsigned VEC_W   = SIP_VEC_W,
    parameter int unsigned TMR_BIT = SIP_TMR_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sip_ops_t         ops,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [VEC_W-1:0] set_data,
    input  logic [VEC_W-1:0] clr_data,
    output logic [VEC_W-1:0] pend_q
);

    localparam logic [VEC_W-1:0] TMR_MASK = VEC_W'(1) << TMR_BIT;

    logic [VEC_W-1:0] after_wr;
    logic [VEC_W-1:0] after_set;
    logic [VEC_W-1:0] after_clr;
    logic [VEC_W-1:0] pend_d;

    // Ordered resolution: write, then set, then clear, then timer
    always_comb begin
        after_wr  = ops.wr  ? wr_data              : pend_q;
        after_set = ops.set ? (after_wr | set_data) : after_wr;
        after_clr = ops.clr ? (after_set & ~clr_data) : after_set;
        pend_d    = ops.tmr ? (after_clr | TMR_MASK) : after_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/sip_lvl_reg.sv
module sip_lvl_reg
    import sip_pkg::*;
#(
    parameter int unsigned LVL_W = SIP_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_wr_en,
    input  logic [LVL_W-1:0] lvl_wr_data,
    output logic [LVL_W-1:0] lvl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (lvl_wr_en) begin
            lvl_q <= lvl_wr_data;
        end
    end

endmodule

// File: rtl/sip_lvl_mask.sv
module sip_lvl_mask
    import sip_pkg::*;
#(
    parameter int unsigned VEC_W   = SIP_VEC_W,
    parameter int unsigned LVL_W   = SIP_LVL_W,
    parameter int unsigned TMR_BIT = SIP_TMR_BIT,
    parameter int unsigned LOCK    = SIP_LOCK
) (
    input  logic [VEC_W-1:0] pend,
    input  logic [LVL_W-1:0] lvl,
    output logic [VEC_W-1:0] req
);

    localparam int unsigned IDX_W = $clog2(VEC_W);
    localparam int unsigned CMP_W = ((IDX_W > LVL_W) ? IDX_W : LVL_W) + 1;

    logic [CMP_W-1:0] lvl_ext;
    logic             below_lock;

    assign lvl_ext    = CMP_W'(lvl);
    assign below_lock = (lvl_ext < CMP_W'(LOCK));

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        if (i == 0 || i == TMR_BIT) begin : g_fixed
            // Edge bits use the fixed lock threshold
            assign req[i] = pend[i] & below_lock;
        end else begin : g_ranked
            // Ranked bits pass only above the current level
            assign req[i] = pend[i] & (CMP_W'(i) > lvl_ext);
        end
    end

endmodule

// File: rtl/sip_filter.sv
module sip_filter
    import sip_pkg::*;
#(
    parameter int unsigned VEC_W   = SIP_VEC_W,
    parameter int unsigned LVL_W   = SIP_LVL_W,
    parameter int unsigned TMR_BIT = SIP_TMR_BIT,
    parameter int unsigned LOCK    = SIP_LOCK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_data,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_data,
    input  logic             tmr_match,
    input  logic             lvl_wr_en,
    input  logic [LVL_W-1:0] lvl_wr_data,
    output logic [VEC_W-1:0] rd_pend,
    output logic [LVL_W-1:0] rd_lvl,
    output logic [VEC_W-1:0] irq_req
);

    sip_ops_t         ops;
    logic [VEC_W-1:0] pend_q;
    logic [LVL_W-1:0] lvl_q;

    assign ops.wr  = wr_en;
    assign ops.set = set_en;
    assign ops.clr = clr_en;
    assign ops.tmr = tmr_match;

    sip_pend_reg #(
        .VEC_W   (VEC_W),
        .TMR_BIT (TMR_BIT)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ops      (ops),
        .wr_data  (wr_data),
        .set_data (set_data),
        .clr_data (clr_data),
        .pend_q   (pend_q)
    );

    sip_lvl_reg #(
        .LVL_W (LVL_W)
    ) u_lvl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_wr_en   (lvl_wr_en),
        .lvl_wr_data (lvl_wr_data),
        .lvl_q       (lvl_q)
    );

    sip_lvl_mask #(
        .VEC_W   (VEC_W),
        .LVL_W   (LVL_W),
        .TMR_BIT (TMR_BIT),
        .LOCK    (LOCK)
    ) u_mask (
        .pend (pend_q),
        .lvl  (lvl_q),
        .req  (irq_req)
    );

    assign rd_pend = pend_q;
    assign rd_lvl  = lvl_q;

endmodule

// File: rtl/sip_filter_chk.sv
module sip_filter_chk
    import sip_pkg::*;
#(
    parameter int unsigned VEC_W   = SIP_VEC_W,
    parameter int unsigned LVL_W   = SIP_LVL_W,
    parameter int unsigned TMR_BIT = SIP_TMR_BIT,
    parameter int unsigned LOCK    = SIP_LOCK
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [VEC_W-1:0] wr_data,
    input logic             set_en,
    input logic [VEC_W-1:0] set_data,
    input logic             clr_en,
    input logic [VEC_W-1:0] clr_data,
    input logic             tmr_match,
    input logic             lvl_wr_en,
    input logic [LVL_W-1:0] lvl_wr_data,
    input logic [VEC_W-1:0] rd_pend,
    input logic [LVL_W-1:0] rd_lvl,
    input logic [VEC_W-1:0] irq_req
);

    localparam int unsigned CMP_W = (($clog2(VEC_W) > LVL_W) ? $clog2(VEC_W) : LVL_W) + 1;

    // R2
    wr_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !set_en && !clr_en && !tmr_match) |=> (rd_pend == $past(wr_data)));

    // R3
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> ((rd_pend & $past(set_data)) == $past(set_data)));

    // R4
    clr_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !tmr_match) |=> ((rd_pend & $past(clr_data)) == '0));

    // R5
    tmr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_match |=> rd_pend[TMR_BIT]);

    // R9
    lvl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr_en |=> (rd_lvl == $past(lvl_wr_data)));

    // R9
    lvl_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !set_en && !clr_en && !tmr_match) |=> $stable(rd_pend));

    // R8
    req_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~rd_pend) == '0));

    // R7
    edge_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CMP_W'(rd_lvl) >= CMP_W'(LOCK)) |-> (!irq_req[0] && !irq_req[TMR_BIT]));

    for (genvar k = 1; k < VEC_W; k++) begin : g_rank
        if (k != TMR_BIT) begin : g_only
            // R8
            rank_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (CMP_W'(k) <= CMP_W'(rd_lvl)) |-> !irq_req[k]);
        end
    end

endmodule

bind sip_filter sip_filter_chk #(
    .VEC_W   (VEC_W),
    .LVL_W   (LVL_W),
    .TMR_BIT (TMR_BIT),
    .LOCK    (LOCK)
) u_sip_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .set_en      (set_en),
    .set_data    (set_data),
    .clr_en      (clr_en),
    .clr_data    (clr_data),
    .tmr_match   (tmr_match),
    .lvl_wr_en   (lvl_wr_en),
    .lvl_wr_data (lvl_wr_data),
    .rd_pend     (rd_pend),
    .rd_lvl      (rd_lvl),
    .irq_req     (irq_req)
);

// File: tb/tb_sip_filter.sv
module tb_sip_filter;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [16:0] wr_data;
    logic        set_en;
    logic [16:0] set_data;
    logic        clr_en;
    logic [16:0] clr_data;
    logic        tmr_match;
    logic        lvl_wr_en;
    logic [3:0]  lvl_wr_data;
    logic [16:0] rd_pend;
    logic [3:0]  rd_lvl;
    logic [16:0] irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [16:0] m_pend;
    logic [3:0]  m_lvl;

    sip_filter dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .set_en(set_en), .set_data(set_data),
        .clr_en(clr_en), .clr_data(clr_data),
        .tmr_match(tmr_match),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_data(lvl_wr_data),
        .rd_pend(rd_pend), .rd_lvl(rd_lvl), .irq_req(irq_req)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [16:0] wd;
        logic        st;
        logic [16:0] sd;
        logic        cl;
        logic [16:0] cd;
        logic        lw;
        logic [3:0]  ld;
        logic        tm;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 17'h00005, 1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 4'd0,  1'b0}, // R2
        '{1'b0, 17'h0,     1'b1, 17'h10100, 1'b0, 17'h0,     1'b0, 4'd0,  1'b0}, // R3
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 17'h00004, 1'b0, 4'd0,  1'b0}, // R4
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 4'd8,  1'b0}, // R9
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 4'd14, 1'b0}, // R7
        '{1'b0, 17'h0,     1'b1, 17'h0C000, 1'b0, 17'h0,     1'b0, 4'd0,  1'b0}, // R8
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 4'd13, 1'b0}, // R7
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 17'h1FFFF, 1'b0, 4'd0,  1'b1}, // R6
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 4'd15, 1'b1}, // R5
        '{1'b1, 17'h00F0F, 1'b1, 17'h000F0, 1'b1, 17'h00003, 1'b1, 4'd2,  1'b0}, // R6
        '{1'b1, 17'h00001, 1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 4'd15, 1'b0}, // R7
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 4'd0,  1'b0}, // R10
        '{1'b0, 17'h0,     1'b0, 17'h0,     1'b0, 17'h0,     1'b1, 4'd0,  1'b0}  // R9
    };

    function automatic string tag_of(int idx);
        case (idx)
            0:       return "R2";
            1:       return "R3";
            2:       return "R4";
            3, 12:   return "R9";
            4, 6, 10: return "R7";
            5:       return "R8";
            7, 9:    return "R6";
            8:       return "R5";
            default: return "R10";
        endcase
    endfunction

    // Expected request lines from the stated rules
    function automatic logic [16:0] exp_req(logic [16:0] p, logic [3:0] l);
        logic [16:0] r;
        for (int i = 0; i < 17; i++) begin
            if (i == 0 || i == 16) r[i] = p[i] && (l < 4'd14);
            else                   r[i] = p[i] && (i > int'(l));
        end
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [16:0] act, logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; set_en = 0; set_data = '0;
        clr_en = 0; clr_data = '0; tmr_match = 0;
        lvl_wr_en = 0; lvl_wr_data = '0;
    endtask

    task automatic apply(vec_t v);
        @(negedge clk);
        wr_en = v.wr; wr_data = v.wd; set_en = v.st; set_data = v.sd;
        clr_en = v.cl; clr_data = v.cd; tmr_match = v.tm;
        lvl_wr_en = v.lw; lvl_wr_data = v.ld;
        if (v.wr) m_pend = v.wd;
        if (v.st) m_pend = m_pend | v.sd;
        if (v.cl) m_pend = m_pend & ~v.cd;
        if (v.tm) m_pend[16] = 1'b1;
        if (v.lw) m_lvl = v.ld;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_all(string tag);
        chk(tag, "pend", rd_pend, m_pend);
        chk(tag, "lvl", 17'(rd_lvl), 17'(m_lvl));
        chk(tag, "req", irq_req, exp_req(m_pend, m_lvl));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        m_pend = '0;
        m_lvl  = '0;
        rst_n  = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "pend", rd_pend, 17'h0);
        chk("R1", "lvl", 17'(rd_lvl), 17'h0);
        chk("R1", "req", irq_req, 17'h0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check_all(tag_of(i));
        end

        // R8 / R7 level sweep with every bit pending
        apply('{1'b1, 17'h1FFFF, 1'b0, 17'h0, 1'b0, 17'h0, 1'b0, 4'd0, 1'b0});
        for (int l = 0; l < 16; l++) begin
            apply('{1'b0, 17'h0, 1'b0, 17'h0, 1'b0, 17'h0, 1'b1, 4'(l), 1'b0});
            check_all((l >= 13) ? "R7" : "R8");
        end

        // R10 lines hold for several idle cycles
        apply('{1'b0, 17'h0, 1'b0, 17'h0, 1'b0, 17'h0, 1'b1, 4'd5, 1'b0});
        repeat (4) begin
            @(negedge clk);
            chk("R10", "req hold", irq_req, exp_req(m_pend, m_lvl));
        end

        // R10 line drops in the cycle its bit is cleared
        apply('{1'b0, 17'h0, 1'b0, 17'h0, 1'b1, 17'h00040, 1'b0, 4'd0, 1'b0});
        chk("R10", "req bit6", 17'(irq_req[6]), 17'h0);
        check_all("R4");

        // R5 timer pulse alone keeps other bits
        apply('{1'b1, 17'h00A0A, 1'b0, 17'h0, 1'b0, 17'h0, 1'b0, 4'd0, 1'b0});
        apply('{1'b0, 17'h0, 1'b0, 17'h0, 1'b0, 17'h0, 1'b0, 4'd0, 1'b1});
        chk("R5", "pend", rd_pend, 17'h10A0A);
        check_all("R5");

        // R6 set then clear of the same bit in one cycle leaves it clear
        apply('{1'b0, 17'h0, 1'b1, 17'h00100, 1'b1, 17'h00100, 1'b0, 4'd0, 1'b0});
        chk("R6", "bit8", 17'(rd_pend[8]), 17'h0);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        m_pend = '0;
        m_lvl  = '0;
        @(negedge clk);
        check_all("R1");

        finish_run();
    end

endmodule